// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the control section of a five-stage load/store pipeline (fetch, decode, execute, memory, write-back). Each cycle it takes the instruction sitting in decode, together with decoded control bits and the register-file read data. It keeps its own copy of the destination tags as the instruction moves through the execute, memory and write-back stages. From those tags it drives the operand multiplexer selects for the execute stage, the write enables for the program counter and the fetch/decode register, a bubble request for the decode/execute register, and a flush for the fetch/decode register.

Conditional branches on equal or not-equal are settled in decode. Both operands pass through a bitwise XOR and an OR reduction, and the operands may be forwarded from the memory or write-back stage. A taken branch therefore costs a single discarded instruction. The block also produces the branch target, which is the incremented PC plus the sign-extended word offset. A branch whose operand is still being computed is held in decode until the value can be forwarded. A load consumed by the instruction right behind it is held in decode in the same way.

Top module: `hazard_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, all stage tags are empty: wb_we_o is 0, both execute selects are 00, and pc_we_o and ifid_we_o are 1 with no bubble and no flush.
- R2: The destination tag of a decode instruction is bits 15..11 when id_rtype_i is 1 and bits 20..16 otherwise. It reaches wb_rd_o three clock edges after the instruction was accepted in decode, with wb_we_o equal to its id_reg_write_i.
- R3: In a stall cycle, the decode/execute tag is loaded empty. That slot never forwards, and three edges later it shows wb_we_o = 0.
- R4: The execute operand selects use 2'b10 for the memory-stage result, 2'b01 for the write-back value and 2'b00 for the register file. Operand A matches source bits 25..21 of the instruction in execute, and operand B matches bits 20..16.
- R5: When the memory stage and the write-back stage both write the same source register, the memory stage wins.
- R6: Register 0, and any stage that does not write a register, is never a forwarding source.
- R7: When the instruction in execute is a load with a nonzero destination, and that destination is a source that decode uses, the block stalls: pc_we_o=0, ifid_we_o=0, idex_bubble_o=1.
- R8: A branch in decode stalls when either of its operands (bits 25..21 and 20..16) is written by the instruction in execute, or by a load in the memory stage. A load ahead of a branch therefore costs two stall cycles, and an ALU result costs one.
- R9: A branch that is not stalled is taken when its operands are equal (id_branch_ne_i=0) or unequal (id_branch_ne_i=1). branch_taken_o and ifid_flush_o are raised only in that case.
- R10: branch_target_o equals id_pc_plus4_i plus bits 15..0 sign-extended and shifted left by two.
- R11: The decode comparator operands come from mem_alu_i when the memory stage writes the source and is not a load, otherwise from wb_data_i when write-back writes it, and otherwise from the register file. Register 0 is excluded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_instr_i | input | 26 | Low 26 bits of the instruction in decode |
| id_rtype_i | input | 1 | Register-format instruction, destination in bits 15..11 |
| id_reg_write_i | input | 1 | Decode instruction writes a register |
| id_mem_read_i | input | 1 | Decode instruction is a load |
| id_uses_rs_i | input | 1 | Decode instruction reads bits 25..21 |
| id_uses_rt_i | input | 1 | Decode instruction reads bits 20..16 |
| id_branch_i | input | 1 | Decode instruction is a conditional branch |
| id_branch_ne_i | input | 1 | Branch on not-equal instead of equal |
| id_pc_plus4_i | input | XLEN | Incremented PC of the decode instruction |
| id_rs_data_i | input | XLEN | Register-file read data, first source |
| id_rt_data_i | input | XLEN | Register-file read data, second source |
| mem_alu_i | input | XLEN | ALU result held in the memory stage |
| wb_data_i | input | XLEN | Value being written back |
| ex_fwd_a_o | output | 2 | Execute operand A select |
| ex_fwd_b_o | output | 2 | Execute operand B select |
| pc_we_o | output | 1 | PC write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| idex_bubble_o | output | 1 | Load decode/execute with cleared control |
| ifid_flush_o | output | 1 | Discard the fetched instruction |
| branch_taken_o | output | 1 | Redirect fetch to branch_target_o |
| branch_target_o | output | XLEN | Branch destination address |
| wb_rd_o | output | 5 | Destination register at write-back |
| wb_we_o | output | 1 | Register write enable at write-back |

## Verification
The hardest case to reach is a load followed directly by a branch on the loaded register. The branch must stall twice, first against the load in execute and then against it in the memory stage, and then compare equal using the forwarded write-back value. The stimulus produces this with a directed load-then-branch pair and holds the branch in decode while the stall lasts. A random phase then draws register numbers from a tiny set, so that tags from two stages often hit the same source, which exercises the priority order and the register-0 exclusion.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW = 5;

  typedef logic [REG_AW-1:0] ridx_t;

  typedef struct packed {
    ridx_t rd;
    logic  rw;
    logic  mr;
  } dtag_t;

  typedef struct packed {
    ridx_t rs;
    ridx_t rt;
    dtag_t d;
  } extag_t;

  typedef struct packed {
    ridx_t rd;
    logic  rw;
  } wtag_t;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_e;
endpackage

// File: rtl/hz_tag_pipe.sv
module hz_tag_pipe
  import hz_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bubble_i,
  input  extag_t id_tag_i,
  output extag_t ex_o,
  output dtag_t  mem_o,
  output wtag_t  wb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_o  <= '0;
      mem_o <= '0;
      wb_o  <= '0;
    end else begin
      ex_o  <= bubble_i ? '0 : id_tag_i;
      mem_o <= ex_o.d;
      wb_o  <= '{rd: mem_o.rd, rw: mem_o.rw};
    end
  end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
(
  input  ridx_t src_i,
  input  ridx_t mem_rd_i,
  input  logic  mem_rw_i,
  input  logic  mem_ok_i,
  input  ridx_t wb_rd_i,
  input  logic  wb_rw_i,
  output fwd_e  sel_o
);
  logic mem_hit, wb_hit;

  assign mem_hit = mem_ok_i && mem_rw_i && (mem_rd_i != '0) && (mem_rd_i == src_i);
  assign wb_hit  = wb_rw_i && (wb_rd_i != '0) && (wb_rd_i == src_i);

  always_comb begin
    sel_o = FWD_RF;
    if (wb_hit)  sel_o = FWD_WB;
    if (mem_hit) sel_o = FWD_MEM;  // younger result overrides
  end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hz_pkg::*;
(
  input  ridx_t rs_i,
  input  ridx_t rt_i,
  input  logic  uses_rs_i,
  input  logic  uses_rt_i,
  input  logic  branch_i,
  input  dtag_t ex_i,
  input  dtag_t mem_i,
  output logic  stall_o
);
  logic ex_nz, mem_nz, load_use, br_on_ex, br_on_load;

  assign ex_nz  = ex_i.rd != '0;
  assign mem_nz = mem_i.rd != '0;

  assign load_use = ex_i.mr && ex_nz &&
                    ((uses_rs_i && ex_i.rd == rs_i) || (uses_rt_i && ex_i.rd == rt_i));
  assign br_on_ex = branch_i && ex_i.rw && ex_nz &&
                    (ex_i.rd == rs_i || ex_i.rd == rt_i);
  assign br_on_load = branch_i && mem_i.mr && mem_nz &&
                      (mem_i.rd == rs_i || mem_i.rd == rt_i);

  assign stall_o = load_use || br_on_ex || br_on_load;
endmodule

// File: rtl/hz_branch_unit.sv
module hz_branch_unit
  import hz_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] rs_data_i,
  input  logic [XLEN-1:0] rt_data_i,
  input  logic [XLEN-1:0] mem_alu_i,
  input  logic [XLEN-1:0] wb_data_i,
  input  fwd_e            sel_a_i,
  input  fwd_e            sel_b_i,
  input  logic            branch_i,
  input  logic            ne_i,
  input  logic            stall_i,
  input  logic [XLEN-1:0] pc4_i,
  input  logic [15:0]     imm_i,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o
);
  localparam int unsigned EXT_W = XLEN - 18;

  logic [XLEN-1:0] op_a, op_b, offs;
  logic            differ;

  function automatic logic [XLEN-1:0] pick(fwd_e s, logic [XLEN-1:0] rf,
                                            logic [XLEN-1:0] m, logic [XLEN-1:0] w);
    case (s)
      FWD_MEM: pick = m;
      FWD_WB:  pick = w;
      default: pick = rf;
    endcase
  endfunction

  assign op_a    = pick(sel_a_i, rs_data_i, mem_alu_i, wb_data_i);
  assign op_b    = pick(sel_b_i, rt_data_i, mem_alu_i, wb_data_i);
  assign differ  = |(op_a ^ op_b);
  assign taken_o = branch_i && !stall_i && (ne_i ? differ : !differ);

  assign offs     = {{EXT_W{imm_i[15]}}, imm_i, 2'b00};
  assign target_o = pc4_i + offs;
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [25:0]     id_instr_i,
  input  logic            id_rtype_i,
  input  logic            id_reg_write_i,
  input  logic            id_mem_read_i,
  input  logic            id_uses_rs_i,
  input  logic            id_uses_rt_i,
  input  logic            id_branch_i,
  input  logic            id_branch_ne_i,
  input  logic [XLEN-1:0] id_pc_plus4_i,
  input  logic [XLEN-1:0] id_rs_data_i,
  input  logic [XLEN-1:0] id_rt_data_i,
  input  logic [XLEN-1:0] mem_alu_i,
  input  logic [XLEN-1:0] wb_data_i,
  output logic [1:0]      ex_fwd_a_o,
  output logic [1:0]      ex_fwd_b_o,
  output logic            pc_we_o,
  output logic            ifid_we_o,
  output logic            idex_bubble_o,
  output logic            ifid_flush_o,
  output logic            branch_taken_o,
  output logic [XLEN-1:0] branch_target_o,
  output logic [REG_AW-1:0] wb_rd_o,
  output logic            wb_we_o
);
  localparam int unsigned NPICK = 4;  // ex A, ex B, id A, id B

  ridx_t  id_rs, id_rt, id_dst;
  extag_t id_tag, ex_tag;
  dtag_t  mem_tag;
  wtag_t  wb_tag;
  logic   stall, taken;
  ridx_t  pick_src [NPICK];
  fwd_e   pick_sel [NPICK];

  assign id_rs  = id_instr_i[25:21];
  assign id_rt  = id_instr_i[20:16];
  assign id_dst = id_rtype_i ? id_instr_i[15:11] : id_instr_i[20:16];

  assign id_tag = '{rs: id_rs, rt: id_rt,
                    d: '{rd: id_dst, rw: id_reg_write_i, mr: id_mem_read_i}};

  hz_tag_pipe u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bubble_i (stall),
    .id_tag_i (id_tag),
    .ex_o     (ex_tag),
    .mem_o    (mem_tag),
    .wb_o     (wb_tag)
  );

  assign pick_src[0] = ex_tag.rs;
  assign pick_src[1] = ex_tag.rt;
  assign pick_src[2] = id_rs;
  assign pick_src[3] = id_rt;

  for (genvar i = 0; i < NPICK; i++) begin : g_pick
    logic mem_ok;
    if (i < 2) begin : g_ex
      assign mem_ok = 1'b1;
    end else begin : g_id
      assign mem_ok = !mem_tag.mr;  // load data not ready for decode compare
    end
    hz_fwd_pick u_pick (
      .src_i    (pick_src[i]),
      .mem_rd_i (mem_tag.rd),
      .mem_rw_i (mem_tag.rw),
      .mem_ok_i (mem_ok),
      .wb_rd_i  (wb_tag.rd),
      .wb_rw_i  (wb_tag.rw),
      .sel_o    (pick_sel[i])
    );
  end

  hz_stall_unit u_stall (
    .rs_i      (id_rs),
    .rt_i      (id_rt),
    .uses_rs_i (id_uses_rs_i),
    .uses_rt_i (id_uses_rt_i),
    .branch_i  (id_branch_i),
    .ex_i      (ex_tag.d),
    .mem_i     (mem_tag),
    .stall_o   (stall)
  );

  hz_branch_unit #(.XLEN(XLEN)) u_br (
    .rs_data_i (id_rs_data_i),
    .rt_data_i (id_rt_data_i),
    .mem_alu_i (mem_alu_i),
    .wb_data_i (wb_data_i),
    .sel_a_i   (pick_sel[2]),
    .sel_b_i   (pick_sel[3]),
    .branch_i  (id_branch_i),
    .ne_i      (id_branch_ne_i),
    .stall_i   (stall),
    .pc4_i     (id_pc_plus4_i),
    .imm_i     (id_instr_i[15:0]),
    .taken_o   (taken),
    .target_o  (branch_target_o)
  );

  assign ex_fwd_a_o     = pick_sel[0];
  assign ex_fwd_b_o     = pick_sel[1];
  assign pc_we_o        = !stall;
  assign ifid_we_o      = !stall;
  assign idex_bubble_o  = stall;
  assign ifid_flush_o   = taken;
  assign branch_taken_o = taken;
  assign wb_rd_o        = wb_tag.rd;
  assign wb_we_o        = wb_tag.rw;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       id_branch_i,
  input logic [1:0] ex_fwd_a_o,
  input logic [1:0] ex_fwd_b_o,
  input logic       pc_we_o,
  input logic       idex_bubble_o,
  input logic       ifid_flush_o,
  input logic       wb_we_o
);
  // R4
  fwd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_fwd_a_o != 2'b11) && (ex_fwd_b_o != 2'b11));

  // R9
  flush_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifid_flush_o |-> pc_we_o);

  // R9
  flush_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifid_flush_o |-> id_branch_i);

  // R3
  bubble_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(idex_bubble_o, 3) |-> !wb_we_o);

  // R8
  stall_max2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(idex_bubble_o) && idex_bubble_o) |=> !idex_bubble_o);
endmodule

bind hazard_ctrl hz_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .id_branch_i   (id_branch_i),
  .ex_fwd_a_o    (ex_fwd_a_o),
  .ex_fwd_b_o    (ex_fwd_b_o),
  .pc_we_o       (pc_we_o),
  .idex_bubble_o (idex_bubble_o),
  .ifid_flush_o  (ifid_flush_o),
  .wb_we_o       (wb_we_o)
);

// File: tb/hazard_ctrl_tb.sv
`timescale 1ns/1ps
module hazard_ctrl_tb;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [25:0]     instr;
  logic            rtype, rw, mr, urs, urt, br, ne;
  logic [XLEN-1:0] pc4, rsd, rtd, malu, wdat;
  logic [1:0]      fa, fb;
  logic            pc_we, ifid_we, bubble, flush, taken, wb_we;
  logic [XLEN-1:0] target;
  logic [4:0]      wb_rd;

  hazard_ctrl #(.XLEN(XLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .id_instr_i(instr), .id_rtype_i(rtype),
    .id_reg_write_i(rw), .id_mem_read_i(mr), .id_uses_rs_i(urs), .id_uses_rt_i(urt),
    .id_branch_i(br), .id_branch_ne_i(ne), .id_pc_plus4_i(pc4),
    .id_rs_data_i(rsd), .id_rt_data_i(rtd), .mem_alu_i(malu), .wb_data_i(wdat),
    .ex_fwd_a_o(fa), .ex_fwd_b_o(fb), .pc_we_o(pc_we), .ifid_we_o(ifid_we),
    .idex_bubble_o(bubble), .ifid_flush_o(flush), .branch_taken_o(taken),
    .branch_target_o(target), .wb_rd_o(wb_rd), .wb_we_o(wb_we)
  );

  int n_chk = 0, n_err = 0;

  // bench model of the stage tags
  logic [4:0] x_rs, x_rt, x_rd, m_rd, w_rd;
  logic       x_rw, x_mr, m_rw, m_mr, w_rw;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fsel(logic [4:0] s, logic mok);
    if (mok && m_rw && m_rd != 0 && m_rd == s) return 2'b10;
    if (w_rw && w_rd != 0 && w_rd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] fval(logic [1:0] s, logic [XLEN-1:0] rf);
    return (s == 2'b10) ? malu : (s == 2'b01) ? wdat : rf;
  endfunction

  function automatic logic [XLEN-1:0] tgt(logic [XLEN-1:0] p, logic [15:0] im);
    return p + {{(XLEN-18){im[15]}}, im, 2'b00};
  endfunction

  // drive one decode slot; returns 1 if stalled
  task automatic cycle(output bit stl, output bit tk);
    logic [4:0] rs, rt;
    logic ldu, bex, bld;
    logic [XLEN-1:0] va, vb;
    #1;
    rs = instr[25:21]; rt = instr[20:16];
    ldu = x_mr && x_rd != 0 && ((urs && x_rd == rs) || (urt && x_rd == rt));
    bex = br && x_rw && x_rd != 0 && (x_rd == rs || x_rd == rt);
    bld = br && m_mr && m_rd != 0 && (m_rd == rs || m_rd == rt);
    stl = ldu || bex || bld;
    va = fval(fsel(rs, !m_mr), rsd);
    vb = fval(fsel(rt, !m_mr), rtd);
    tk = br && !stl && (ne ? (va != vb) : (va == vb));
    chk("R4/R5/R6 fwd A", {30'd0, fa}, {30'd0, fsel(x_rs, 1'b1)});
    chk("R4/R5/R6 fwd B", {30'd0, fb}, {30'd0, fsel(x_rt, 1'b1)});
    chk("R7/R8 pc_we", {31'd0, pc_we}, {31'd0, !stl});
    chk("R7/R8 ifid_we", {31'd0, ifid_we}, {31'd0, !stl});
    chk("R7/R8 bubble", {31'd0, bubble}, {31'd0, stl});
    chk("R9/R11 taken", {31'd0, taken}, {31'd0, tk});
    chk("R9 flush", {31'd0, flush}, {31'd0, tk});
    chk("R10 target", target, tgt(pc4, instr[15:0]));
    chk("R2/R3 wb_we", {31'd0, wb_we}, {31'd0, w_rw});
    if (w_rw) chk("R2 wb_rd", {27'd0, wb_rd}, {27'd0, w_rd});
    // state after the coming edge
    w_rd = m_rd; w_rw = m_rw;
    m_rd = x_rd; m_rw = x_rw; m_mr = x_mr;
    if (stl) begin
      x_rs = 0; x_rt = 0; x_rd = 0; x_rw = 0; x_mr = 0;
    end else begin
      x_rs = rs; x_rt = rt; x_rd = rtype ? instr[15:11] : rt; x_rw = rw; x_mr = mr;
    end
    @(negedge clk);
  endtask

  task automatic set_nop();
    instr = '0; rtype = 0; rw = 0; mr = 0; urs = 0; urt = 0; br = 0; ne = 0;
  endtask

  // issue until accepted; insert flushed slot after a taken branch
  task automatic issue();
    bit stl, tk;
    do cycle(stl, tk); while (stl);
    if (tk) begin
      set_nop();
      cycle(stl, tk);
    end
  endtask

  task automatic alu(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
    set_nop(); instr = {a, b, d, 11'd0}; rtype = 1; rw = 1; urs = 1; urt = 1; issue();
  endtask

  task automatic load(input logic [4:0] d, input logic [4:0] a);
    set_nop(); instr = {a, d, 16'h0004}; rw = 1; mr = 1; urs = 1; issue();
  endtask

  task automatic branch(input logic [4:0] a, input logic [4:0] b, input bit bne,
                        input logic [15:0] im);
    set_nop(); instr = {a, b, im}; br = 1; ne = bne; urs = 1; urt = 1; issue();
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    x_rs = 0; x_rt = 0; x_rd = 0; x_rw = 0; x_mr = 0;
    m_rd = 0; m_rw = 0; m_mr = 0; w_rd = 0; w_rw = 0;
    set_nop();
    pc4 = 32'h100; rsd = 0; rtd = 0; malu = 0; wdat = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 wb_we", {31'd0, wb_we}, 32'd0);
    chk("R1 fwd A", {30'd0, fa}, 32'd0);
    chk("R1 fwd B", {30'd0, fb}, 32'd0);
    chk("R1 pc_we", {31'd0, pc_we}, 32'd1);
    chk("R1 bubble", {31'd0, bubble}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release wb_we", {31'd0, wb_we}, 32'd0);

    // R7: load then use
    load(5'd2, 5'd1);
    alu(5'd3, 5'd2, 5'd0);
    // R8: ALU then branch on it (one stall), R11 forwarded from memory stage
    malu = 32'h77; rsd = 32'h77; rtd = 32'h0;
    alu(5'd4, 5'd1, 5'd1);
    branch(5'd4, 5'd0, 1'b1, 16'hfffe);
    malu = 0; rsd = 0;
    // R8: load then branch (two stalls), compare through write-back value
    load(5'd5, 5'd1);
    wdat = 32'h9; rtd = 32'h9; rsd = 32'h1;
    branch(5'd5, 5'd6, 1'b0, 16'h0010);
    wdat = 0; rtd = 0; rsd = 0;
    // R5: two writes to r7 then a reader
    alu(5'd7, 5'd1, 5'd1);
    alu(5'd7, 5'd2, 5'd2);
    alu(5'd8, 5'd7, 5'd7);
    // R6: writes to r0 are never forwarded
    alu(5'd0, 5'd1, 5'd1);
    alu(5'd9, 5'd0, 5'd0);
    // R2/R3: drain
    set_nop(); issue(); issue(); issue();

    // random phase
    for (int k = 0; k < 3000; k++) begin
      int kind;
      kind = $urandom_range(0, 3);
      set_nop();
      instr = {5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
               5'($urandom_range(0, 3)), 11'($urandom)};
      rsd  = $urandom_range(0, 2); rtd = $urandom_range(0, 2);
      malu = $urandom_range(0, 2); wdat = $urandom_range(0, 2);
      pc4  = $urandom;
      case (kind)
        0: begin rtype = 1; rw = 1'($urandom); urs = 1; urt = 1; end
        1: begin rw = 1; mr = 1; urs = 1; end
        2: begin br = 1; ne = 1'($urandom); urs = 1; urt = 1; end
        default: begin rw = 1'($urandom); urs = 1'($urandom); urt = 1'($urandom); end
      endcase
      issue();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule